// File: doc/BRIEF.md
# Odd-Times-Power-of-Two Tick Prescaler

This block derives a slow, single-cycle enable tick from the system clock. A typical target is a tick rate near 1 MHz for a serial bus engine. Software writes one configuration byte. That byte holds an odd base divisor, a power-of-two prescale exponent and a run bit. The resulting division ratio is the product of the two factors.

Software keeps a table that maps each input clock frequency to a configuration byte. Some examples: 0x81 suits a 3 MHz input, 0x8C suits an 8 MHz input and 0x9C suits a 128 MHz input. After a new byte is written, the downstream logic should wait a short settling time before it starts any bus activity. Every write restarts the division from zero, so the phase of the tick is tied to the moment of the write.

Top module: `oddpow_prescaler`

## Requirements
- R1: After reset, `divActive` is 0, `tickEn` is 0 and `cfgRdData` reads 0x00.
- R2: `cfgRdData` returns all eight bits of the last byte written, including bits 6:5. Bits 6:5 have no effect on the tick.
- R3: While bit 7 of the stored byte is 0, `tickEn` stays 0 on every cycle, whatever bits 4:0 hold.
- R4: `divActive` equals bit 7 of the stored byte.
- R5: Bits 1:0 hold a base value d, which selects an odd base divide of 2·d+1 (1, 3, 5 or 7).
- R6: Bits 4:2 hold an exponent p, which selects a prescale of 2^p (1 to 128).
- R7: With bit 7 set, `tickEn` is high for exactly one clock in every N = (2·d+1)·2^p clocks.
- R8: The byte 0x80 gives N = 1, and `tickEn` is then high on every cycle.
- R9: Number the clock cycles from 1, starting with the cycle right after the write edge. After a write that sets bit 7, `tickEn` is high in cycles N, 2N, 3N and so on, and low in all others. This holds even when the write lands partway through a period.
- R10: Clearing bit 7 holds both counters at zero. When bit 7 is set again later, timing starts afresh as stated in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Write strobe for the configuration byte |
| cfgWrData | input | 8 | Configuration byte: bit 7 run, bits 4:2 exponent p, bits 1:0 base d |
| cfgRdData | output | 8 | Readback of the stored configuration byte |
| tickEn | output | 1 | Single-cycle enable pulse at the divided rate |
| divActive | output | 1 | High while the divider is running |

## Verification
The assertions assume that `cfgWrEn` is a clean synchronous strobe and that reset is applied before the first write. They also assume that configuration changes reach the block only through the write port, because the counter range checks rely on each write clearing the counters in the same edge that loads a new limit. The bench drives writes only at falling edges and holds the strobe for exactly one clock. It sweeps all 32 enabled divisor settings, with bits 6:5 varied across the sweep, and checks every cycle of two full periods against the arithmetic ratio. It also re-writes a setting in the middle of a period and toggles the run bit to confirm that the phase restarts.

// File: rtl/oddpow_pkg.sv
package oddpow_pkg;
  // Strobes from the control part to the counting datapath
  typedef struct packed {
    logic clear;  // force both counters to zero
    logic run;    // counting permitted
  } cntStrobe_t;
endpackage

// File: rtl/oddpow_ctrl.sv
module oddpow_ctrl
  import oddpow_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int BASE_W = 2,
  parameter int PRE_W  = 3,
  localparam int PRE_CNT_W  = (1 << PRE_W) - 1,
  localparam int BASE_CNT_W = BASE_W + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [REG_W-1:0]      wrData,
  output logic [REG_W-1:0]      rdData,
  output logic                  active,
  output cntStrobe_t            strobe,
  output logic [PRE_CNT_W-1:0]  preLimit,
  output logic [BASE_CNT_W-1:0] baseLimit
);
  localparam int RUN_BIT = REG_W - 1;

  logic [REG_W-1:0]     divReg;
  logic [BASE_W-1:0]    baseField;
  logic [PRE_W-1:0]     preField;
  logic [PRE_CNT_W:0]   preOneHot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divReg <= '0;
    else if (wrEn) divReg <= wrData;
  end

  assign baseField = divReg[BASE_W-1:0];
  assign preField  = divReg[BASE_W+PRE_W-1:BASE_W];
  assign preOneHot = (PRE_CNT_W+1)'(1) << preField;

  always_comb begin
    preLimit     = preOneHot[PRE_CNT_W-1:0] - PRE_CNT_W'(1);
    baseLimit    = {baseField, 1'b0};
    strobe.run   = divReg[RUN_BIT];
    strobe.clear = wrEn | ~divReg[RUN_BIT];
  end

  assign rdData = divReg;
  assign active = divReg[RUN_BIT];

  // R2: readback holds the byte written one edge earlier
  p_readback_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdData == $past(wrData)));
  // R4: the active flag follows the run bit of the written byte
  p_active_bit_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (active == $past(wrData[RUN_BIT])));
  // R2: without a write the stored byte does not move
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdData));
endmodule

// File: rtl/oddpow_datapath.sv
module oddpow_datapath
  import oddpow_pkg::*;
#(
  parameter int BASE_W = 2,
  parameter int PRE_W  = 3,
  localparam int PRE_CNT_W  = (1 << PRE_W) - 1,
  localparam int BASE_CNT_W = BASE_W + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cntStrobe_t            strobe,
  input  logic [PRE_CNT_W-1:0]  preLimit,
  input  logic [BASE_CNT_W-1:0] baseLimit,
  output logic                  tick
);
  logic [PRE_CNT_W-1:0]  preCnt;
  logic [BASE_CNT_W-1:0] baseCnt;
  logic                  preWrap;

  assign preWrap = strobe.run && (preCnt == preLimit);
  assign tick    = preWrap && (baseCnt == baseLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              preCnt <= '0;
    else if (strobe.clear)  preCnt <= '0;
    else if (strobe.run)    preCnt <= preWrap ? '0 : preCnt + PRE_CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              baseCnt <= '0;
    else if (strobe.clear)  baseCnt <= '0;
    else if (preWrap)       baseCnt <= tick ? '0 : baseCnt + BASE_CNT_W'(1);
  end

  // R3: no tick while the divider is stopped
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |-> !tick);
  // R10: a clear leaves both counters at zero
  p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (preCnt == '0 && baseCnt == '0));
  // R6: prescale counter never passes its limit
  p_pre_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run |-> (preCnt <= preLimit));
  // R5: base counter never passes its limit
  p_base_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run |-> (baseCnt <= baseLimit));
  // R7: ratios above one never give back-to-back ticks
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !strobe.clear && (preLimit != '0 || baseLimit != '0)) |=> !tick);
endmodule

// File: rtl/oddpow_prescaler.sv
module oddpow_prescaler
  import oddpow_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int BASE_W = 2,
  parameter int PRE_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [REG_W-1:0] cfgWrData,
  output logic [REG_W-1:0] cfgRdData,
  output logic             tickEn,
  output logic             divActive
);
  localparam int PRE_CNT_W  = (1 << PRE_W) - 1;
  localparam int BASE_CNT_W = BASE_W + 1;

  cntStrobe_t            strobe;
  logic [PRE_CNT_W-1:0]  preLimit;
  logic [BASE_CNT_W-1:0] baseLimit;

  oddpow_ctrl #(.REG_W(REG_W), .BASE_W(BASE_W), .PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(cfgWrEn), .wrData(cfgWrData),
    .rdData(cfgRdData), .active(divActive), .strobe(strobe),
    .preLimit(preLimit), .baseLimit(baseLimit));

  oddpow_datapath #(.BASE_W(BASE_W), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .preLimit(preLimit), .baseLimit(baseLimit), .tick(tickEn));

  // R8: with divide-by-one selected and no write pending, tick is constant high
  p_ratio_one_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdData[REG_W-1] && cfgRdData[BASE_W+PRE_W-1:0] == '0 && !cfgWrEn) |-> tickEn);
endmodule

// File: tb/oddpow_prescaler_tb.sv
module oddpow_prescaler_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = 8'h00;
  logic [7:0] cfgRdData;
  logic       tickEn;
  logic       divActive;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oddpow_prescaler u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .tickEn(tickEn), .divActive(divActive));

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive one write, return at the falling edge of cycle 1 after the write edge
  task automatic writeReg(input logic [7:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // compare tickEn over cycles 1..len with the ratio n (n==0 means stopped)
  task automatic checkRun(input string req, input int n, input int len);
    int bad = 0;
    int firstBad = 0;
    int badAct = 0;
    for (int i = 1; i <= len; i++) begin
      int exp = (n != 0 && (i % n) == 0) ? 1 : 0;
      if (int'(tickEn) != exp && bad == 0) begin
        firstBad = i; badAct = int'(tickEn);
      end
      if (int'(tickEn) != exp) bad++;
      if (i < len) @(negedge clk);
    end
    nChecks++;
    if (bad != 0) begin
      nFails++;
      $display("FAIL %s: ratio %0d cycle %0d actual %0d expected %0d (%0d bad)",
               req, n, firstBad, badAct, (n != 0 && firstBad % n == 0), bad);
    end
  endtask

  function automatic int ratioOf(input logic [7:0] v);
    return (2 * int'(v[1:0]) + 1) * (1 << int'(v[4:2]));
  endfunction

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    nChecks++; nFails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 active", int'(divActive), 0);
    check("R1 tick", int'(tickEn), 0);
    check("R1 readback", int'(cfgRdData), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3/R2: disabled byte with fields set
    writeReg(8'h65);
    check("R2 readback 0x65", int'(cfgRdData), 8'h65);
    check("R4 active low", int'(divActive), 0);
    checkRun("R3 stopped", 0, 60);

    // R8 ratio one
    writeReg(8'h80);
    check("R4 active high", int'(divActive), 1);
    checkRun("R8 every cycle", 1, 20);

    // R5/R6/R7 sweep of every enabled setting, bits 6:5 varied
    for (int p = 0; p < 8; p++) begin
      for (int d = 0; d < 4; d++) begin
        v = {1'b1, 2'(p + d), 3'(p), 2'(d)};
        writeReg(v);
        check("R2 sweep readback", int'(cfgRdData), int'(v));
        checkRun("R7 sweep ratio (R5 base, R6 prescale)", ratioOf(v), 2 * ratioOf(v));
      end
    end

    // R9 rewrite in the middle of a period (28)
    writeReg(8'h8B);
    repeat (10) @(negedge clk);
    writeReg(8'h8B);
    checkRun("R9 same-value restart", 28, 56);
    writeReg(8'h85);
    repeat (4) @(negedge clk);
    writeReg(8'h89);
    checkRun("R9 new-value restart", 12, 36);

    // R10 stop then restart
    writeReg(8'h05);
    check("R4 active after stop", int'(divActive), 0);
    checkRun("R10 stopped", 0, 40);
    writeReg(8'h85);
    checkRun("R10 restart from zero", 6, 30);

    // R2 upper bits read back but ratio unaffected
    writeReg(8'hE1);
    check("R2 readback 0xE1", int'(cfgRdData), 8'hE1);
    checkRun("R2 bits 6:5 ignored", 3, 12);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule